// File: doc/BRIEF.md
# UART Interrupt Aggregation Logic

This block gathers the interrupt causes of one serial channel into a single request line. Four causes are tracked in a source-pending vector: received data, a receive error, a transmit request and a modem-status change. A mask vector suppresses selected causes. The masked result is held in a pending vector, and the request line is the OR of that vector. Software acknowledges a cause by writing a one to its bit, either in the pending register or in the source-pending register. Either write removes the cause from both views.

The block also produces the transmit-FIFO trigger request. A 3-bit level code from the FIFO control register is scaled by a multiplier. The multiplier depends on the channel type, which is fixed by a parameter. The scaled level is compared with the current transmit FIFO count. While the FIFO is enabled and the count has fallen to the level or below, the transmit cause is raised.

The FIFOs and the serial engines sit outside this block and deliver single-cycle event pulses to it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Cause bit positions are fixed. Bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. A one-cycle pulse on a cause input sets its bit in `src_pend_o` on the next clock edge, and the bit stays set until it is cleared.
- R2: `pend_o` always equals `src_pend_o & ~mask_o`.
- R3: `irq_o` is high exactly when any bit of `pend_o` is set.
- R4: A write to the pending register (`pend_clr_we`) clears, on the next edge, every bit of both `pend_o` and `src_pend_o` where `pend_clr_data` holds a one. Bits where the data holds zero are left unchanged.
- R5: A write to the source-pending register (`src_clr_we`) clears the source bits where `src_clr_data` holds a one. Bits where the data holds zero are left unchanged.
- R6: A mask write loads `mask_wdata` into `mask_o` on the next edge. `pend_o` and `irq_o` follow in that same cycle, without any new event.
- R7: `tx_level_o` equals the transmit level code (FIFO control bits [10:8], input `tx_lvl_code`) times a multiplier. The multiplier is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R8: `tx_trig_o` is high exactly when `fifo_en` (FIFO control bit 0) is set and `tx_count` is less than or equal to `tx_level_o`. While it is high, the transmit source bit is set on each edge.
- R9: A pulse on `ev_tx_done` (one transmitted byte completed) sets the transmit source bit, whether or not the FIFO is enabled.
- R10: After reset, `src_pend_o`, `mask_o`, `pend_o` and `irq_o` are all zero.
- R11: When a cause is raised in the same cycle as a write that clears it, the cause wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx | input | 1 | Receive data event pulse |
| ev_err | input | 1 | Receive error event pulse |
| ev_tx_done | input | 1 | Transmitted-byte completion pulse |
| ev_modem | input | 1 | Modem status change pulse |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| fifo_en | input | 1 | FIFO enable (control bit 0) |
| tx_lvl_code | input | 3 | Transmit trigger level code (control bits [10:8]) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | Mask write data |
| pend_clr_we | input | 1 | Pending register write strobe (write-1-to-clear) |
| pend_clr_data | input | 4 | Pending register write data |
| src_clr_we | input | 1 | Source-pending register write strobe (write-1-to-clear) |
| src_clr_data | input | 4 | Source-pending register write data |
| src_pend_o | output | 4 | Source-pending vector |
| mask_o | output | 4 | Mask vector |
| pend_o | output | 4 | Masked pending vector |
| irq_o | output | 1 | Interrupt request line |
| tx_level_o | output | 8 | Scaled transmit trigger level |
| tx_trig_o | output | 1 | Transmit FIFO trigger request |

## Verification
The clear checks assume that a clear write is judged only in cycles where no cause is raised and the trigger is low, because a raised cause overrides the clear (R11). The bench therefore disables the FIFO, or holds the count above the level, whenever it expects a clear to stick. The event checks assume pulses last one cycle and arrive synchronously. The driver changes every input only on the falling edge and holds it for exactly one rising edge. The level is only meaningful for a stable code, so the code is likewise changed only between edges.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int SRC_N     = 4;
    localparam int IDX_RX    = 0;
    localparam int IDX_ERR   = 1;
    localparam int IDX_TX    = 2;
    localparam int IDX_MODEM = 3;

    localparam int CODE_W    = 3;
    localparam int MAX_MULT  = 32;
    localparam int LVL_W     = $clog2(((1 << CODE_W) - 1) * MAX_MULT + 1);

    typedef struct packed {
        logic modem;
        logic tx;
        logic err;
        logic rx;
    } src_vec_t;

    // Scale factor applied to the transmit level code for each channel type.
    function automatic int unsigned level_mult(input int unsigned chan);
        case (chan)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_tx_trigger.sv
module uirq_tx_trigger
    import uart_irq_pkg::*;
#(
    parameter int unsigned CHANNEL = 0,
    parameter int          CNT_W   = 8
) (
    input  logic                fifo_en,
    input  logic [CODE_W-1:0]   code,
    input  logic [CNT_W-1:0]    count,
    output logic [LVL_W-1:0]    level,
    output logic                trig
);
    localparam int unsigned MULT  = level_mult(CHANNEL);
    localparam int          CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    generate
        if (MULT == 0) begin : g_no_level
            assign level = '0;
        end else begin : g_scaled
            localparam logic [LVL_W-1:0] MULT_V = LVL_W'(MULT);
            assign level = LVL_W'(code) * MULT_V;
        end
    endgenerate

    assign trig = fifo_en && (CMP_W'(count) <= CMP_W'(level));

endmodule

// File: rtl/uirq_src_reg.sv
module uirq_src_reg
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_vec_t  set_i,
    input  src_vec_t  clr_i,
    output src_vec_t  src_q,
    output src_vec_t  src_next
);
    // A cause raised in the same cycle as its clear is kept.
    always_comb begin
        src_next = (src_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_next;
    end

endmodule

// File: rtl/uirq_mask_pend.sv
module uirq_mask_pend
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mask_we,
    input  src_vec_t  mask_wdata,
    input  src_vec_t  src_next,
    output src_vec_t  mask_q,
    output src_vec_t  pend_q,
    output logic      irq_q
);
    src_vec_t mask_next;
    src_vec_t pend_next;

    always_comb begin
        mask_next = mask_we ? mask_wdata : mask_q;
        pend_next = src_next & ~mask_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_next;
            pend_q <= pend_next;
            irq_q  <= |pend_next;
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned CHANNEL = 0,
    parameter int          CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ev_rx,
    input  logic                      ev_err,
    input  logic                      ev_tx_done,
    input  logic                      ev_modem,
    input  logic [CNT_W-1:0]          tx_count,
    input  logic                      fifo_en,
    input  logic [2:0]                tx_lvl_code,
    input  logic                      mask_we,
    input  logic [3:0]                mask_wdata,
    input  logic                      pend_clr_we,
    input  logic [3:0]                pend_clr_data,
    input  logic                      src_clr_we,
    input  logic [3:0]                src_clr_data,
    output logic [3:0]                src_pend_o,
    output logic [3:0]                mask_o,
    output logic [3:0]                pend_o,
    output logic                      irq_o,
    output logic [7:0]                tx_level_o,
    output logic                      tx_trig_o
);
    src_vec_t set_v, clr_v, src_q, src_nx, mask_q, pend_q;
    logic     trig;
    logic [LVL_W-1:0] level;

    uirq_tx_trigger #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_trig (
        .fifo_en (fifo_en),
        .code    (tx_lvl_code),
        .count   (tx_count),
        .level   (level),
        .trig    (trig)
    );

    always_comb begin
        set_v       = '0;
        set_v.rx    = ev_rx;
        set_v.err   = ev_err;
        set_v.tx    = ev_tx_done | trig;
        set_v.modem = ev_modem;
        clr_v = (pend_clr_we ? src_vec_t'(pend_clr_data) : src_vec_t'('0))
              | (src_clr_we  ? src_vec_t'(src_clr_data)  : src_vec_t'('0));
    end

    uirq_src_reg u_src (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_v),
        .clr_i    (clr_v),
        .src_q    (src_q),
        .src_next (src_nx)
    );

    uirq_mask_pend u_mp (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (src_vec_t'(mask_wdata)),
        .src_next   (src_nx),
        .mask_q     (mask_q),
        .pend_q     (pend_q),
        .irq_q      (irq_o)
    );

    assign src_pend_o = src_q;
    assign mask_o     = mask_q;
    assign pend_o     = pend_q;
    assign tx_level_o = 8'(level);
    assign tx_trig_o  = trig;

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_rx,
    input logic             ev_err,
    input logic             ev_tx_done,
    input logic             ev_modem,
    input logic             fifo_en,
    input logic             mask_we,
    input logic [3:0]       mask_wdata,
    input logic             pend_clr_we,
    input logic [3:0]       pend_clr_data,
    input logic             src_clr_we,
    input logic [3:0]       src_clr_data,
    input logic [3:0]       src_pend_o,
    input logic [3:0]       mask_o,
    input logic [3:0]       pend_o,
    input logic             irq_o,
    input logic             tx_trig_o
);
    logic quiet;
    assign quiet = !ev_rx && !ev_err && !ev_tx_done && !ev_modem && !tx_trig_o;

    assert_rx_sets_R1: assert property (@(posedge clk) disable iff (rst)
        ev_rx |=> src_pend_o[0]);
    assert_err_sets_R1: assert property (@(posedge clk) disable iff (rst)
        ev_err |=> src_pend_o[1]);
    assert_modem_sets_R1: assert property (@(posedge clk) disable iff (rst)
        ev_modem |=> src_pend_o[3]);
    assert_pend_masked_R2: assert property (@(posedge clk) disable iff (rst)
        pend_o == (src_pend_o & ~mask_o));
    assert_irq_any_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pend_o != 4'b0));
    assert_pend_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (pend_clr_we && quiet) |=> ((src_pend_o & $past(pend_clr_data)) == 4'b0));
    assert_src_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (src_clr_we && quiet) |=> ((src_pend_o & $past(src_clr_data)) == 4'b0));
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_o == $past(mask_wdata)));
    assert_trig_sets_R8: assert property (@(posedge clk) disable iff (rst)
        tx_trig_o |=> src_pend_o[2]);
    assert_trig_needs_en_R8: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> !tx_trig_o);
    assert_txdone_sets_R9: assert property (@(posedge clk) disable iff (rst)
        ev_tx_done |=> src_pend_o[2]);

endmodule

bind uart_irq_ctrl uirq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx_done(ev_tx_done), .ev_modem(ev_modem), .fifo_en(fifo_en),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pend_clr_we(pend_clr_we), .pend_clr_data(pend_clr_data),
    .src_clr_we(src_clr_we), .src_clr_data(src_clr_data),
    .src_pend_o(src_pend_o), .mask_o(mask_o), .pend_o(pend_o),
    .irq_o(irq_o), .tx_trig_o(tx_trig_o)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       ev_rx = 0, ev_err = 0, ev_tx_done = 0, ev_modem = 0;
    logic [7:0] tx_count = 0;
    logic       fifo_en = 0;
    logic [2:0] tx_lvl_code = 0;
    logic       mask_we = 0, pend_clr_we = 0, src_clr_we = 0;
    logic [3:0] mask_wdata = 0, pend_clr_data = 0, src_clr_data = 0;
    logic [3:0] src_pend_o, mask_o, pend_o;
    logic       irq_o, tx_trig_o;
    logic [7:0] tx_level_o;

    logic [3:0] s1, m1, p1, s3, m3, p3, s9, m9, p9;
    logic       i1, i3, i9, t1, t3, t9;
    logic [7:0] l1, l3, l9;

    uart_irq_ctrl #(.CHANNEL(0)) i_uart_irq_ctrl (
        .clk, .rst, .ev_rx, .ev_err, .ev_tx_done, .ev_modem, .tx_count,
        .fifo_en, .tx_lvl_code, .mask_we, .mask_wdata, .pend_clr_we,
        .pend_clr_data, .src_clr_we, .src_clr_data, .src_pend_o, .mask_o,
        .pend_o, .irq_o, .tx_level_o, .tx_trig_o);

    uart_irq_ctrl #(.CHANNEL(1)) i_ch1 (
        .clk, .rst, .ev_rx, .ev_err, .ev_tx_done, .ev_modem, .tx_count,
        .fifo_en, .tx_lvl_code, .mask_we, .mask_wdata, .pend_clr_we,
        .pend_clr_data, .src_clr_we, .src_clr_data, .src_pend_o(s1),
        .mask_o(m1), .pend_o(p1), .irq_o(i1), .tx_level_o(l1), .tx_trig_o(t1));

    uart_irq_ctrl #(.CHANNEL(3)) i_ch3 (
        .clk, .rst, .ev_rx, .ev_err, .ev_tx_done, .ev_modem, .tx_count,
        .fifo_en, .tx_lvl_code, .mask_we, .mask_wdata, .pend_clr_we,
        .pend_clr_data, .src_clr_we, .src_clr_data, .src_pend_o(s3),
        .mask_o(m3), .pend_o(p3), .irq_o(i3), .tx_level_o(l3), .tx_trig_o(t3));

    uart_irq_ctrl #(.CHANNEL(9)) i_ch9 (
        .clk, .rst, .ev_rx, .ev_err, .ev_tx_done, .ev_modem, .tx_count,
        .fifo_en, .tx_lvl_code, .mask_we, .mask_wdata, .pend_clr_we,
        .pend_clr_data, .src_clr_we, .src_clr_data, .src_pend_o(s9),
        .mask_o(m9), .pend_o(p9), .irq_o(i9), .tx_level_o(l9), .tx_trig_o(t9));

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    typedef struct {
        logic [3:0] src;
        logic [3:0] mask;
        logic [3:0] pend;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [3:0] m_src = 0, m_mask = 0;

    function automatic int tb_mult(input int ch);
        if (ch == 0) return 32;
        if (ch == 1 || ch == 4) return 8;
        if (ch == 2 || ch == 3) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected register state.
    task automatic step(input logic [3:0] ev, input logic fen, input logic [2:0] code,
                        input logic [7:0] cnt, input logic mwe, input logic [3:0] md,
                        input logic pwe, input logic [3:0] pd, input logic swe,
                        input logic [3:0] sd, input string tag);
        int   lvl;
        logic trig;
        logic [3:0] set_v, clr_v;
        exp_t e;
        @(negedge clk);
        {ev_modem, ev_tx_done, ev_err, ev_rx} = ev;
        fifo_en = fen; tx_lvl_code = code; tx_count = cnt;
        mask_we = mwe; mask_wdata = md;
        pend_clr_we = pwe; pend_clr_data = pd;
        src_clr_we = swe; src_clr_data = sd;
        #1;
        lvl  = int'(code) * tb_mult(0);
        trig = fen && (int'(cnt) <= lvl);
        chk(tx_level_o == 8'(lvl), {"R7 level ", tag}, tx_level_o, lvl);
        chk(tx_trig_o == trig, {"R8 trigger ", tag}, tx_trig_o, trig);
        set_v = ev | {1'b0, trig, 2'b00};
        clr_v = (pwe ? pd : 4'b0) | (swe ? sd : 4'b0);
        m_src = (m_src & ~clr_v) | set_v;
        if (mwe) m_mask = md;
        @(posedge clk);
        #1;
        e.src = m_src; e.mask = m_mask; e.pend = m_src & ~m_mask;
        e.irq = (e.pend != 0); e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare registered outputs against the scoreboard.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(src_pend_o == e.src, {"src ", e.tag}, src_pend_o, e.src);
            chk(mask_o == e.mask,    {"mask ", e.tag}, mask_o, e.mask);
            chk(pend_o == e.pend,    {"R2 pend ", e.tag}, pend_o, e.pend);
            chk(irq_o == e.irq,      {"R3 irq ", e.tag}, irq_o, e.irq);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        chk(src_pend_o == 0 && mask_o == 0 && pend_o == 0 && irq_o == 0,
            "R10 reset zero", {src_pend_o, mask_o, pend_o}, 0);

        step(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 rx bit0");
        step(4'b1010, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 err+modem");
        step(4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 hold");
        step(4'b0000, 0, 0, 0, 1, 4'hF, 0, 0, 0, 0, "R6 mask all");
        step(4'b0000, 0, 0, 0, 1, 4'h4, 0, 0, 0, 0, "R6 unmask");
        step(4'b0000, 0, 0, 0, 0, 0, 1, 4'h3, 0, 0, "R4 pend clear");
        step(4'b0000, 0, 0, 0, 0, 0, 0, 0, 1, 4'h8, "R5 src clear");
        step(4'b0100, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 tx done masked");
        step(4'b0000, 0, 0, 0, 1, 4'h0, 0, 0, 0, 0, "R6 unmask shows tx");
        step(4'b0000, 0, 0, 0, 0, 0, 1, 4'h4, 0, 0, "R4 clear tx");
        step(4'b0001, 0, 0, 0, 0, 0, 0, 0, 1, 4'h1, "R11 set beats clear");
        step(4'b0000, 0, 0, 0, 0, 0, 1, 4'h1, 0, 0, "R4 clear rx");
        step(4'b0000, 1, 3'd1, 8'd40, 0, 0, 0, 0, 0, 0, "R8 above level");
        step(4'b0000, 1, 3'd1, 8'd32, 0, 0, 0, 0, 0, 0, "R8 equal level");
        step(4'b0000, 1, 3'd1, 8'd33, 0, 0, 0, 0, 0, 0, "R8 sticky");
        step(4'b0000, 1, 3'd1, 8'd33, 0, 0, 1, 4'h4, 0, 0, "R4 clear trig");
        step(4'b0000, 0, 3'd1, 8'd0, 0, 0, 0, 0, 0, 0, "R8 disabled");
        step(4'b0000, 0, 3'd7, 8'd0, 0, 0, 0, 0, 0, 0, "R7 code7");
        // R7: other channel types at code 7
        chk(l1 == 8'd56, "R7 ch1 code7", l1, 56);
        chk(l3 == 8'd14, "R7 ch3 code7", l3, 14);
        chk(l9 == 8'd0,  "R7 ch9 code7", l9, 0);
        step(4'b0000, 0, 3'd3, 8'd0, 0, 0, 0, 0, 0, 0, "R7 code3");
        chk(l1 == 8'd24, "R7 ch1 code3", l1, 24);
        chk(l3 == 8'd6,  "R7 ch3 code3", l3, 6);
        chk(l9 == 8'd0,  "R7 ch9 code3", l9, 0);
        step(4'b0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule